// File: doc/BRIEF.md
# Countdown Timer with Periodic and One-Shot Modes

This block is a down-counting timer on a small register bus. Software writes a control word that holds the enable, the repeat mode and the period in one register. While it is enabled, the counter steps down by one on each pulse of the tick input picked by a source-select register. When a tick arrives while the count is already zero, the timer signals an expiration. It then either reloads the period and carries on, or switches itself off.

Each expiration shows up two ways. It sets a sticky pending flag, which drives the interrupt output and which software clears by writing a one to it. It also produces a one-cycle pulse on a dedicated output, so that a watchdog or any other counter can count expirations. The tick pulses come from outside the block. Each tick input is a single-cycle pulse in the block's clock domain.

Top module: `countdown_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero, `irq` is 0, `expire` is 0 and `bus_rdata` is 0.
- R2: The control register at byte offset 0x0 holds three fields: bit 31 is the enable, bit 30 selects repeat mode (1 = periodic, 0 = one-shot) and bits 27:0 hold the period. Bits 29:28 read as zero. A write with bit 31 set loads the counter with the newly written period.
- R3: While enabled, the counter decreases by one on each cycle in which the selected tick is high. It holds its value when there is no tick. A tick in the same cycle as a control write is ignored.
- R4: A tick that finds the count at zero raises `expire` for exactly one cycle, starting on the next clock. The first expiration therefore comes on the (period+1)-th counted tick after the load.
- R5: Each expiration sets the sticky pending flag, which reads as bit 30 of the status register at offset 0x4. `irq` equals this flag.
- R6: Writing the status register with bit 30 = 1 clears the flag. Writing it with bit 30 = 0 has no effect. If an expiration happens in the same cycle as a clear, the flag ends up set.
- R7: In periodic mode, an expiration reloads the stored period and the timer keeps running. With ticks every k cycles, consecutive pulses are (period+1)*k cycles apart.
- R8: In one-shot mode, the first expiration clears the enable bit (bit 31 then reads 0). No further expiration follows.
- R9: Writing the control register with bit 31 = 0 stops counting and expirations at once. The written mode and period bits are still stored and read back.
- R10: The low log2(NUM_SRC) bits of the source-select register at offset 0x8 pick which `tick_in` bit drives the counter. Value 0 selects `tick_in[0]`, the microsecond tick. Other bits read zero. A new selection applies from the cycle after the write.
- R11: `bus_rdata` returns, one clock after `bus_addr` is presented, the register contents before that clock edge. Unmapped addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_in | input | NUM_SRC | Tick pulses, one per source |
| irq | output | 1 | Level interrupt, equal to the pending flag |
| expire | output | 1 | One-cycle pulse per expiration |

## Verification
The counting path is driven by three tick patterns: a tick every cycle, a tick every third cycle, and a pseudo-random tick. It is also driven by a source that never ticks. The every-cycle pattern pins down the off-by-one of the (period+1)-th tick. The every-third-cycle pattern separates a design that counts ticks from one that counts clocks. The silent source shows that the count holds. A long phase of random register writes, mixed with small periods and both modes, lets clears and control writes collide with expirations in the same cycle. These collisions separate the set-wins and write-blocks-tick priorities from the other possible orderings. A behavioural model checks the outputs and the read data on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned OFS_CTRL = 32'h0;
  localparam int unsigned OFS_STAT = 32'h4;
  localparam int unsigned OFS_SRC  = 32'h8;

  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned MODE_BIT = 30;
  localparam int unsigned PEND_BIT = 30;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_SRC  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [WORD_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a == OFS_CTRL) s = SEL_CTRL;
    else if (a == OFS_STAT) s = SEL_STAT;
    else if (a == OFS_SRC) s = SEL_SRC;
    return s;
  endfunction

endpackage

// File: rtl/tmr_tick_mux.sv
module tmr_tick_mux #(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 2
) (
  input  logic [NUM_SRC-1:0] tick_in,
  input  logic [SRC_W-1:0]   sel,
  output logic               tick
);

  generate
    if (NUM_SRC == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel;
      assign tick = tick_in[0];
    end else if ((1 << SRC_W) == NUM_SRC) begin : g_pow2
      assign tick = tick_in[sel];
    end else begin : g_guarded
      always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
          if (sel == SRC_W'(i)) tick = tick_in[i];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int PERIOD_W = 28
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                en,
  input  logic                periodic,
  input  logic [PERIOD_W-1:0] period,
  input  logic                ctrl_wr,
  input  logic                load,
  input  logic [PERIOD_W-1:0] load_val,
  output logic                expire_now,
  output logic                expire_q
);

  logic [PERIOD_W-1:0] cnt;
  logic                at_zero;
  logic                step;

  assign at_zero    = (cnt == '0);
  assign step       = en & tick & ~ctrl_wr;
  assign expire_now = step & at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= expire_now;
      if (load) begin
        cnt <= load_val;
      end else if (step) begin
        if (at_zero) begin
          if (periodic) cnt <= period;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !ctrl_wr && cnt != '0) |=> cnt == PERIOD_W'($past(cnt) - 1'b1));

  // R3
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ctrl_wr) |=> $stable(cnt));

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_now && periodic) |=> cnt == $past(period));

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int ADDR_W   = 12,
  parameter int PERIOD_W = 28,
  parameter int SRC_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                expire_now,
  output logic                en,
  output logic                periodic,
  output logic [PERIOD_W-1:0] period,
  output logic [SRC_W-1:0]    src_sel,
  output logic                pending,
  output logic                ctrl_wr,
  output logic                load
);
  import tmr_pkg::*;

  reg_sel_e    sel;
  logic        stat_wr;
  logic        src_wr;
  logic [31:0] rd_word;

  assign sel     = decode_addr({{(WORD_W-ADDR_W){1'b0}}, bus_addr});
  assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
  assign stat_wr = bus_wr && (sel == SEL_STAT);
  assign src_wr  = bus_wr && (sel == SEL_SRC);
  assign load    = ctrl_wr && bus_wdata[EN_BIT];

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_CTRL: begin
        rd_word[EN_BIT]         = en;
        rd_word[MODE_BIT]       = periodic;
        rd_word[PERIOD_W-1:0]   = period;
      end
      SEL_STAT: rd_word[PEND_BIT] = pending;
      SEL_SRC:  rd_word[SRC_W-1:0] = src_sel;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      periodic  <= 1'b0;
      period    <= '0;
      src_sel   <= '0;
      pending   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_word;
      if (ctrl_wr) begin
        en       <= bus_wdata[EN_BIT];
        periodic <= bus_wdata[MODE_BIT];
        period   <= bus_wdata[PERIOD_W-1:0];
      end else if (expire_now && !periodic) begin
        en <= 1'b0;
      end
      if (src_wr) src_sel <= bus_wdata[SRC_W-1:0];
      if (expire_now) pending <= 1'b1;
      else if (stat_wr && bus_wdata[PEND_BIT]) pending <= 1'b0;
    end
  end

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    expire_now |=> pending);

  // R6
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !bus_wdata[PEND_BIT] && pending) |=> pending);

  // R8
  oneshot_off_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_now && !periodic) |=> !en);

  // R9
  stop_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !bus_wdata[EN_BIT]) |=> !en);

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer #(
  parameter int ADDR_W   = 12,
  parameter int PERIOD_W = 28,
  parameter int NUM_SRC  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] tick_in,
  output logic               irq,
  output logic               expire
);

  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic                en;
  logic                periodic;
  logic [PERIOD_W-1:0] period;
  logic [SRC_W-1:0]    src_sel;
  logic                pending;
  logic                ctrl_wr;
  logic                load;
  logic                tick;
  logic                expire_now;
  logic                expire_q;

  tmr_regs #(.ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire_now(expire_now),
    .en(en), .periodic(periodic), .period(period), .src_sel(src_sel),
    .pending(pending), .ctrl_wr(ctrl_wr), .load(load)
  );

  tmr_tick_mux #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_mux (
    .tick_in(tick_in), .sel(src_sel), .tick(tick)
  );

  tmr_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .en(en), .periodic(periodic),
    .period(period), .ctrl_wr(ctrl_wr), .load(load),
    .load_val(bus_wdata[PERIOD_W-1:0]), .expire_now(expire_now),
    .expire_q(expire_q)
  );

  assign irq    = pending;
  assign expire = expire_q;

  // R4
  pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(expire) |-> $past(en));

endmodule

// File: tb/test_countdown_timer.sv
module test_countdown_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_in = '0;
  logic        irq;
  logic        expire;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit run_cmp = 0;
  logic [31:0] tlfsr = 32'h1234_5678;
  logic [31:0] rlfsr = 32'hCAFE_F00D;

  // reference model state
  int          m_cnt, m_period, m_sel;
  bit          m_en, m_per, m_pend, m_exp;
  logic [31:0] m_rdata;

  always #2 clk = ~clk;

  countdown_timer i_countdown_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
    .irq(irq), .expire(expire)
  );

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // tick patterns: every third cycle, every cycle, random, never
  always @(negedge clk) begin
    cyc++;
    tlfsr = xs(tlfsr);
    tick_in[0] = (cyc % 3 == 0);
    tick_in[1] = 1'b1;
    tick_in[2] = tlfsr[7];
    tick_in[3] = 1'b0;
  end

  // behavioural reference, advanced at each rising edge
  always @(posedge clk) begin
    bit t, cw, sw, rw, ex;
    if (rst) begin
      m_cnt = 0; m_period = 0; m_sel = 0;
      m_en = 0; m_per = 0; m_pend = 0; m_exp = 0; m_rdata = 0;
    end else begin
      t  = tick_in[m_sel];
      cw = bus_wr && bus_addr == 12'h0;
      sw = bus_wr && bus_addr == 12'h4;
      rw = bus_wr && bus_addr == 12'h8;
      case (bus_addr)
        12'h0:   m_rdata = {m_en, m_per, 2'b00, 28'(m_period)};
        12'h4:   m_rdata = {1'b0, m_pend, 30'd0};
        12'h8:   m_rdata = 32'(m_sel);
        default: m_rdata = 32'd0;
      endcase
      ex = m_en && t && m_cnt == 0 && !cw;
      if (cw) begin
        m_en = bus_wdata[31];
        m_per = bus_wdata[30];
        m_period = int'(bus_wdata[27:0]);
        if (bus_wdata[31]) m_cnt = m_period;
      end else if (m_en && t) begin
        if (m_cnt == 0) begin
          if (m_per) m_cnt = m_period;
          else m_en = 0;
        end else m_cnt = m_cnt - 1;
      end
      if (ex) m_pend = 1;
      else if (sw && bus_wdata[30]) m_pend = 0;
      if (rw) m_sel = int'(bus_wdata[1:0]);
      m_exp = ex;
    end
  end

  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      chk(irq == m_pend, "R5 irq vs model", 32'(irq), 32'(m_pend));
      chk(expire == m_exp, "R4 expire vs model", 32'(expire), 32'(m_exp));
      chk(bus_rdata == m_rdata, "R11 rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic wait_pulse(output int c);
    c = 0;
    while (!expire && c < 200) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic count_pulses(input int n, output int k);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (expire) k++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    int c, k;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
    chk(expire == 1'b0, "R1 expire after reset", 32'(expire), 0);
    chk(bus_rdata == 0, "R1 rdata after reset", bus_rdata, 0);
    rd(12'h0, 32'h0, "R1 ctrl reset");
    rd(12'h4, 32'h0, "R1 status reset");
    rd(12'h8, 32'h0, "R1 source reset");
    run_cmp = 1;

    // R4 / R8: one-shot, period 3, tick every cycle
    wr(12'h8, 32'h1);
    wr(12'h0, 32'h8000_0003);
    wait_pulse(c);
    chk(c == 4, "R4 ticks to first expiry", c, 4);
    @(negedge clk);
    chk(expire == 1'b0, "R4 pulse is one cycle", 32'(expire), 0);
    rd(12'h0, 32'h0000_0003, "R8 enable self-cleared");
    rd(12'h4, 32'h4000_0000, "R5 pending bit 30");
    count_pulses(20, k);
    chk(k == 0, "R8 no second expiry", k, 0);

    // R6 clear semantics
    wr(12'h4, 32'hBFFF_FFFF);
    chk(irq == 1'b1, "R6 write 0 keeps flag", 32'(irq), 1);
    wr(12'h4, 32'h4000_0000);
    chk(irq == 1'b0, "R6 write 1 clears flag", 32'(irq), 0);

    // R7 periodic, period 2, tick every third cycle
    wr(12'h8, 32'h0);
    wr(12'h0, 32'hC000_0002);
    wait_pulse(c);
    @(negedge clk);
    wait_pulse(c);
    chk(c == 8, "R7 periodic interval", c + 1, 9);
    rd(12'h0, 32'hC000_0002, "R2 ctrl readback");

    // R9 stop
    wr(12'h0, 32'h4000_0002);
    count_pulses(40, k);
    chk(k == 0, "R9 stopped timer silent", k, 0);
    rd(12'h0, 32'h4000_0002, "R9 fields kept");

    // R10 / R3: silent source holds, then switch to every-cycle tick
    wr(12'h8, 32'hFFFF_FFFF);
    rd(12'h8, 32'h3, "R10 source readback width");
    wr(12'h0, 32'h8000_0005);
    count_pulses(20, k);
    chk(k == 0, "R3 holds without ticks", k, 0);
    wr(12'h8, 32'h1);
    wait_pulse(c);
    chk(c == 6, "R10 R3 new source counts", c, 6);

    // R11 unmapped address
    wr(12'hC, 32'hFFFF_FFFF);
    rd(12'hC, 32'h0, "R11 unmapped reads zero");
    rd(12'h8, 32'h1, "R11 unmapped write ignored");

    // random register traffic, checked by the model each clock
    for (int i = 0; i < 3000; i++) begin
      rlfsr = xs(rlfsr);
      if (rlfsr[9:8] == 2'b00) begin
        case (rlfsr[11:10])
          2'd0: wr(12'h0, {rlfsr[31], rlfsr[30], 27'd0, rlfsr[2:0]});
          2'd1: wr(12'h4, rlfsr);
          2'd2: wr(12'h8, {30'd0, rlfsr[13], ~rlfsr[12] & rlfsr[14]});
          default: wr(12'hC, rlfsr);
        endcase
      end else begin
        bus_addr = {8'd0, rlfsr[17:16], 2'b00};
        @(negedge clk);
      end
    end
    finish_run();
  end

endmodule